// File: doc/BRIEF.md
# Virtual Interrupt Flag Gate

This block sits between a host interrupt source and one guest context. It keeps a virtual interrupt-enable flag for the guest. That flag is separate from the physical flag, which the block always reports as set. When the guest emulation signals an interrupt-disable or interrupt-enable instruction, only the virtual flag changes. The block also reports how far the guest instruction pointer advances. Each of these emulated instructions is one byte long.

Incoming interrupt vectors pass straight through when the guest has interrupts enabled and the consumer is ready. Otherwise they wait in a small first-in first-out queue. The queue drains one vector per cycle once the guest has re-enabled interrupts and the consumer is ready. A vector that finds the queue full is discarded, and a sticky overflow flag records the loss.

Top module: `vif_gate`

## Requirements
- R1: `phys_if_o` is 1 in every cycle, including while reset is asserted. Guest disable and enable events never change it.
- R2: `guest_cli_i` clears `virt_if_o` from the next clock edge. `guest_sti_i` sets it from the next edge. When both are high in the same cycle, the disable wins.
- R3: `ip_adv_o` shows, in the same cycle, how many emulated one-byte instructions are signalled. The value is `guest_cli_i + guest_sti_i`, so 0, 1 or 2.
- R4: When `virt_if_o` is 1, the queue is empty, `deliver_ready_i` is 1 and `irq_valid_i` is 1, the block raises `dlv_valid_o` in that same cycle with `dlv_vector_o` equal to `irq_vector_i`.
- R5: While `virt_if_o` is 0, `dlv_valid_o` stays 0 and every arriving vector is queued.
- R6: Queued vectors leave in arrival order, one per cycle, while `virt_if_o` and `deliver_ready_i` are both 1. A vector that arrives while older ones are queued goes behind them. This includes a vector arriving in the same cycle as an enable.
- R7: A vector that arrives while `virt_if_o` is 1 but `deliver_ready_i` is 0 is queued, not lost.
- R8: The queue holds `DEPTH` vectors (8 by default). A vector is discarded when it arrives with the queue full and no entry leaving in that cycle. The discard sets `ovf_o` from the next edge, and `ovf_o` then stays 1 until reset.
- R9: Reset (`rst_n` low, asynchronous) makes `virt_if_o` 0, empties the queue and clears `ovf_o`.
- R10: `dlv_valid_o` is 1 only in cycles where `deliver_ready_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guest_cli_i | input | 1 | Guest executed an emulated interrupt-disable |
| guest_sti_i | input | 1 | Guest executed an emulated interrupt-enable |
| irq_valid_i | input | 1 | An interrupt vector arrives this cycle |
| irq_vector_i | input | VEC_W | Arriving vector number |
| deliver_ready_i | input | 1 | Guest-side consumer can accept a vector |
| phys_if_o | output | 1 | Physical interrupt flag, always 1 |
| virt_if_o | output | 1 | Guest virtual interrupt flag |
| ip_adv_o | output | 2 | Guest instruction pointer advance this cycle |
| dlv_valid_o | output | 1 | A vector is delivered this cycle |
| dlv_vector_o | output | VEC_W | Delivered vector number |
| ovf_o | output | 1 | Sticky queue-overflow flag |

## Verification
The bench builds the block with the default values: a queue depth of 8 and 8-bit vectors. With this shallow queue, eight arrivals during a disabled window fill it, and the ninth reaches overflow within a few cycles. Directed sequences and random traffic therefore often hit the full queue, including pushes that coincide with a drain. The 8-bit vectors let every queued entry carry a distinct value, so any reordering during a drain shows up in the delivered numbers.

// File: rtl/vif_gate_pkg.sv
package vif_gate_pkg;
  localparam int unsigned IP_ADV_W = 2;
  typedef logic [IP_ADV_W-1:0] ip_adv_t;
endpackage

// File: rtl/vif_flag_ctrl.sv
module vif_flag_ctrl
  import vif_gate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cli_i,
  input  logic    sti_i,
  output logic    vif_o,
  output ip_adv_t ip_adv_o
);
  logic vif_q, vif_d, vif_en;

  always_comb begin
    vif_en = cli_i | sti_i;
    vif_d  = vif_q;
    if (cli_i)      vif_d = 1'b0;
    else if (sti_i) vif_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vif_q <= 1'b0;
    else if (vif_en) vif_q <= vif_d;
  end

  assign vif_o    = vif_q;
  assign ip_adv_o = ip_adv_t'(cli_i) + ip_adv_t'(sti_i);

  // R2: disable takes effect on the next edge
  a_r2_cli_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !vif_o);
  // R2: a lone enable sets the flag on the next edge
  a_r2_sti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sti_i && !cli_i) |=> vif_o);
endmodule

// File: rtl/vif_pend_fifo.sv
module vif_pend_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [VEC_W-1:0] din_i,
  input  logic             pop_i,
  output logic [VEC_W-1:0] head_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [VEC_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, accept, drop, pop_ok;

  always_comb begin
    full    = (cnt_q == FULL_CNT);
    empty_o = (cnt_q == '0);
    pop_ok  = pop_i & ~empty_o;
    accept  = push_i & (~full | pop_ok);
    drop    = push_i & ~accept;
    wr_d    = accept ? ((wr_q == LAST) ? '0 : wr_q + 1'b1) : wr_q;
    rd_d    = pop_ok ? ((rd_q == LAST) ? '0 : rd_q + 1'b1) : rd_q;
    cnt_d   = cnt_q + CW'(accept) - CW'(pop_ok);
    ovf_d   = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_q] <= din_i;
  end

  assign head_o = mem_q[rd_q];
  assign ovf_o  = ovf_q;

  // R8: occupancy never exceeds the configured depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R8: overflow flag is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R8: a vector refused at a full queue raises overflow next cycle
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> ovf_q);
  // R6: the gate only drains a non-empty queue
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/vif_gate.sv
module vif_gate
  import vif_gate_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             guest_cli_i,
  input  logic             guest_sti_i,
  input  logic             irq_valid_i,
  input  logic [VEC_W-1:0] irq_vector_i,
  input  logic             deliver_ready_i,
  output logic             phys_if_o,
  output logic             virt_if_o,
  output logic [1:0]       ip_adv_o,
  output logic             dlv_valid_o,
  output logic [VEC_W-1:0] dlv_vector_o,
  output logic             ovf_o
);
  logic             vif;
  ip_adv_t          ip_adv;
  logic             q_empty, q_push, q_pop, bypass, can_send;
  logic [VEC_W-1:0] q_head;

  vif_flag_ctrl u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cli_i    (guest_cli_i),
    .sti_i    (guest_sti_i),
    .vif_o    (vif),
    .ip_adv_o (ip_adv)
  );

  always_comb begin
    can_send = vif & deliver_ready_i;
    bypass   = can_send & q_empty & irq_valid_i;
    q_pop    = can_send & ~q_empty;
    q_push   = irq_valid_i & ~bypass;
  end

  vif_pend_fifo #(.DEPTH(DEPTH), .VEC_W(VEC_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (q_push),
    .din_i   (irq_vector_i),
    .pop_i   (q_pop),
    .head_o  (q_head),
    .empty_o (q_empty),
    .ovf_o   (ovf_o)
  );

  assign phys_if_o    = 1'b1;
  assign virt_if_o    = vif;
  assign ip_adv_o     = ip_adv;
  assign dlv_valid_o  = bypass | q_pop;
  assign dlv_vector_o = q_empty ? irq_vector_i : q_head;

  // R5: nothing is delivered while the guest has interrupts masked
  a_r5_hold_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_if_o |-> !dlv_valid_o);
  // R10: delivery only toward a ready consumer
  a_r10_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid_o |-> deliver_ready_i);
endmodule

// File: tb/vif_gate_tb_top.sv
module vif_gate_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned VEC_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cli = 1'b0, sti = 1'b0, ivld = 1'b0, rdy = 1'b0;
  logic [VEC_W-1:0] ivec = '0;
  logic             phys_if, virt_if, dvld, ovf;
  logic [1:0]       ip_adv;
  logic [VEC_W-1:0] dvec;

  int n_chk = 0, n_fail = 0;

  logic [VEC_W-1:0] mq [$];
  logic mvif = 1'b0, movf = 1'b0;

  always #5 clk = ~clk;

  vif_gate #(.DEPTH(DEPTH), .VEC_W(VEC_W)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .guest_cli_i (cli), .guest_sti_i (sti),
    .irq_valid_i (ivld), .irq_vector_i (ivec), .deliver_ready_i (rdy),
    .phys_if_o (phys_if), .virt_if_o (virt_if), .ip_adv_o (ip_adv),
    .dlv_valid_o (dvld), .dlv_vector_o (dvec), .ovf_o (ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_valid(logic v, logic r);
    return mvif && r && (mq.size() > 0 || v);
  endfunction

  task automatic step(input logic c, input logic s, input logic v,
                      input logic [VEC_W-1:0] vec, input logic r);
    logic ev;
    @(negedge clk);
    cli = c; sti = s; ivld = v; ivec = vec; rdy = r;
    #1;
    ev = exp_valid(v, r);
    chk("R1 phys flag", int'(phys_if), 1);
    chk("R2 virtual flag", int'(virt_if), int'(mvif));
    chk("R3 ip advance", int'(ip_adv), int'(c) + int'(s));
    chk("R4 R5 R7 R10 delivery valid", int'(dvld), int'(ev));
    if (ev)
      chk("R4 R6 delivered vector", int'(dvec),
          int'(mq.size() > 0 ? mq[0] : vec));
    chk("R8 overflow flag", int'(ovf), int'(movf));
    // model update for the coming edge
    if (ev && mq.size() > 0) void'(mq.pop_front());
    else if (ev) v = 1'b0;
    if (v) begin
      if (mq.size() < DEPTH) mq.push_back(vec);
      else movf = 1'b1;
    end
    if (c) mvif = 1'b0;
    else if (s) mvif = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cli = 0; sti = 0; ivld = 0; rdy = 0;
    #1;
    chk("R9 reset virt flag", int'(virt_if), 0);
    chk("R9 reset overflow", int'(ovf), 0);
    chk("R1 phys flag in reset", int'(phys_if), 1);
    chk("R9 reset no delivery", int'(dvld), 0);
    mq.delete(); mvif = 1'b0; movf = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R5: fill the queue while masked
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 8'(8'h10 + i), 1);
    // R8: ninth arrival is dropped and flagged
    step(0, 0, 1, 8'hEE, 1);
    step(0, 0, 0, 8'h00, 1);
    // R6: enable with a new vector in the same cycle, older drain first
    do_reset();
    step(0, 0, 1, 8'h21, 1);
    step(0, 0, 1, 8'h22, 1);
    step(0, 1, 1, 8'h23, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 8'h00, 1);
    // R7: enabled but not ready, then ready
    step(0, 0, 1, 8'h31, 0);
    step(0, 0, 1, 8'h32, 0);
    step(0, 0, 1, 8'h33, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8'h00, 1);
    // R4: immediate bypass; R2 R3 both events together
    step(0, 0, 1, 8'h44, 1);
    step(1, 1, 0, 8'h00, 1);
    step(0, 0, 1, 8'h45, 1);
    step(0, 1, 0, 8'h00, 0);
    // R8 with simultaneous drain at full
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, 8'(8'h50 + i), 1);
    step(0, 1, 0, 8'h00, 1);
    step(0, 0, 1, 8'h5F, 1);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 8'h00, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 1000 == 999) do_reset();
      step(($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 3) != 0,
           8'($urandom), ($urandom % 4) != 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule